// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is a serial-peripheral-interface master that a small processor drives through a byte-wide register bus. Software sets the bit order, clock polarity and sampling phase, and the serial clock rate, in control and divider registers. Writing a byte to the data register launches one exchange of eight bits. When the exchange finishes, the received byte waits in the data register and a completion flag is raised. A small general-purpose port carries the slave-select line on bit 3. Software drives that line directly, or the controller pulls it low for the length of each exchange.

Three status flags report a finished exchange, a write made too early (a collision) and a mode fault. A mode fault happens when the slave-select pin is an input and is pulled low while the block is an enabled master. The fault takes the block out of master mode and cuts off any exchange in progress. A flag clears only when software reads the status register and then reads the data register. Two interrupt lines are provided, one for completion and one for faults.

The register bus is single-cycle and has no back-pressure. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high. A read of status or data has its side effect at that same edge. No port of this block streams data, so the block has no valid/ready handshake.

Top module: `spi_host_ctrl`

## Requirements
- R1: The registers decode at fixed byte offsets: control 0x00, auxiliary control 0x01, divider 0x04, status 0x05, data 0x09, port 0x0D, direction 0x10. Every register resets to zero. The auxiliary control register reads back the full written byte. The divider reads back only bits 6:4 and 2:0. The port and direction registers read back their low 4 bits.
- R2: When the block is enabled as master and idle, a data write launches an exchange of 16 clock edges. Each half period of SCK lasts (P+1)·2^E system cycles, where P is divider bits 6:4 and E is divider bits 2:0. The first edge comes one half period after the write edge.
- R3: SCK rests at the polarity bit (control bit 3) whenever no exchange runs. With phase bit (control bit 2) at 0, MOSI carries the first bit from the write edge onward, MISO is sampled on leading edges and MOSI changes on trailing edges. With the phase bit at 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R4: With control bit 0 set, data moves least-significant bit first in both directions. With it clear, data moves most-significant bit first.
- R5: A finished exchange sets status bit 7. A read of the data register then returns the received byte.
- R6: A flag clears only after a status read that saw it set, followed by a data read. A data read with no such status read before it leaves the flags unchanged.
- R7: A data write while an exchange is running is ignored and sets status bit 6. The byte sent on MOSI is still the first one.
- R8: A mode fault occurs when control bits 6 (enable) and 4 (master) are set, direction bit 3 is 0 and port input bit 3 is low. The fault sets status bit 4, clears control bits 6 and 4, and aborts the exchange, so no completion flag follows.
- R9: irq_done equals control bit 7 ANDed with status bit 7. irq_fault equals control bit 7 ANDed with status bit 4.
- R10: With control bit 6 clear, SCK holds the polarity level, MOSI is low and data writes start nothing.
- R11: port_out mirrors the port register and port_oe mirrors the direction register. When control bit 1 and direction bit 3 are both set, port_out bit 3 is low during an exchange and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (status and data reads have side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| port_in | input | 4 | General port inputs; bit 3 is the slave-select sense |
| port_out | output | 4 | General port outputs; bit 3 is the slave select |
| port_oe | output | 4 | Port output enables |
| irq_done | output | 1 | Completion interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |

## Verification
The assertions check four rules on every cycle. SCK rests at the polarity level whenever the shifter is idle. A completion always leaves the done flag set. A flag survives every cycle that has no data read. A fault always removes master mode and stops the shifter. The bench's scenarios are needed for the rest, because each depends on a sequence of events. These are the exact edge timing under several divider settings, bit order and phase under loopback, the status-then-data clear ordering, the ignored collision write, and the aborted exchange after a fault.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int REG_W      = 8;
  localparam int REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_AUX   = 5'h01;
  localparam logic [REG_ADDR_W-1:0] OFS_DIV   = 5'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_STAT  = 5'h05;
  localparam logic [REG_ADDR_W-1:0] OFS_DATA  = 5'h09;
  localparam logic [REG_ADDR_W-1:0] OFS_PORT  = 5'h0D;
  localparam logic [REG_ADDR_W-1:0] OFS_DIR   = 5'h10;

  // control bit positions
  localparam int C_IE  = 7;
  localparam int C_EN  = 6;
  localparam int C_MST = 4;
  localparam int C_POL = 3;
  localparam int C_PHA = 2;
  localparam int C_SSO = 1;
  localparam int C_LSB = 0;

  // status bit positions
  localparam int S_DONE = 7;
  localparam int S_COL  = 6;
  localparam int S_FLT  = 4;

  // divider fields
  localparam int PRE_W   = 3;
  localparam int PRE_LSB = 4;
  localparam int EXP_W   = 3;
  localparam int EXP_LSB = 0;

  localparam int SS_BIT = 3;

  typedef struct packed {
    logic ie;
    logic en;
    logic mst;
    logic pol;
    logic pha;
    logic sso;
    logic lsb;
  } ctl_t;
endpackage

// File: rtl/spi_host_baud.sv
module spi_host_baud #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CNT_W   = PRE_W + MAX_EXP + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    half_m1 = ((CNT_W'(pre) + CNT_W'(1)) << expo) - CNT_W'(1);
    tick    = run && (cnt == half_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (tick)       cnt <= '0;
    else                 cnt <= cnt + CNT_W'(1);
  end

  // the count never passes the half-period limit while running
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= half_m1);
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck_tog,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_next
);
  localparam int BW    = $clog2(DATA_W);
  localparam int EW    = BW + 1;
  localparam int EDGES = 2 * DATA_W;

  logic [EW-1:0]     edge_idx;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_sr;
  logic              leading;
  logic              last;
  logic              sample_now;

  function automatic logic pick(input logic [DATA_W-1:0] d,
                                input logic [BW-1:0] i,
                                input logic lsb);
    logic [BW-1:0] j;
    j = lsb ? i : (BW'(DATA_W - 1) - i);
    return d[j];
  endfunction

  always_comb begin
    bit_idx    = edge_idx[EW-1:1];
    leading    = ~edge_idx[0];
    last       = (edge_idx == EW'(EDGES - 1));
    sample_now = busy && tick && (leading ^ cpha);
    done       = busy && tick && last;
    if (!sample_now)    rx_next = rx_sr;
    else if (lsb_first) rx_next = {miso, rx_sr[DATA_W-1:1]};
    else                rx_next = {rx_sr[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sck_tog  <= 1'b0;
      edge_idx <= '0;
      mosi     <= 1'b0;
      tx_q     <= '0;
      rx_sr    <= '0;
    end else if (abort) begin
      busy     <= 1'b0;
      sck_tog  <= 1'b0;
      edge_idx <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      sck_tog  <= 1'b0;
      edge_idx <= '0;
      tx_q     <= tx_data;
      if (!cpha) mosi <= pick(tx_data, '0, lsb_first);
    end else if (busy && tick) begin
      sck_tog  <= ~sck_tog;
      edge_idx <= last ? '0 : edge_idx + EW'(1);
      rx_sr    <= rx_next;
      if (leading && cpha)
        mosi <= pick(tx_q, bit_idx, lsb_first);
      if (!leading && !cpha && !last)
        mosi <= pick(tx_q, bit_idx + BW'(1), lsb_first);
      if (last) busy <= 1'b0;
    end
  end

  // an exchange ends with the clock back at its resting phase
  p_end_at_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !sck_tog));
  // a start never lands on a running exchange
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/spi_host_flags.sv
module spi_host_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_col,
  input  logic set_flt,
  input  logic rd_stat,
  input  logic rd_data,
  output logic done_f,
  output logic col_f,
  output logic flt_f
);
  logic [2:0] flags;
  logic [2:0] armed;
  logic [2:0] clr;

  always_comb begin
    clr    = rd_data ? armed : 3'b000;
    done_f = flags[2];
    col_f  = flags[1];
    flt_f  = flags[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (flags & ~clr) | {set_done, set_col, set_flt};
      if (rd_stat)      armed <= flags;
      else if (rd_data) armed <= '0;
    end
  end

  // a flag survives every cycle without a data read
  p_done_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_f && !rd_data) |=> done_f);
  p_fault_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_f && !rd_data) |=> flt_f);
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  output logic                  sck,
  output logic                  mosi,
  input  logic                  miso,
  input  logic [PORT_W-1:0]     port_in,
  output logic [PORT_W-1:0]     port_out,
  output logic [PORT_W-1:0]     port_oe,
  output logic                  irq_done,
  output logic                  irq_fault
);
  ctl_t              ctl_q;
  logic [REG_W-1:0]  aux_q;
  logic [PRE_W-1:0]  pre_q;
  logic [EXP_W-1:0]  exp_q;
  logic [PORT_W-1:0] port_q;
  logic [PORT_W-1:0] dir_q;
  logic [REG_W-1:0]  rx_hold;

  logic wr_ctrl, wr_aux, wr_div, wr_data, wr_port, wr_dir;
  logic rd_stat, rd_data;
  logic fault, start, abort, set_col;
  logic busy, sck_tog, mosi_q, done, tick;
  logic done_f, col_f, flt_f;
  logic ss_auto;
  logic [REG_W-1:0] rx_next;
  logic [REG_W-1:0] stat_v;
  logic [REG_W-1:0] ctl_v;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    wr_aux  = bus_wr && (bus_addr == OFS_AUX);
    wr_div  = bus_wr && (bus_addr == OFS_DIV);
    wr_data = bus_wr && (bus_addr == OFS_DATA);
    wr_port = bus_wr && (bus_addr == OFS_PORT);
    wr_dir  = bus_wr && (bus_addr == OFS_DIR);
    rd_stat = bus_rd && (bus_addr == OFS_STAT);
    rd_data = bus_rd && (bus_addr == OFS_DATA);

    fault   = ctl_q.en && ctl_q.mst && !dir_q[SS_BIT] && !port_in[SS_BIT];
    abort   = fault || (busy && !(ctl_q.en && ctl_q.mst));
    start   = wr_data && ctl_q.en && ctl_q.mst && !busy && !fault;
    set_col = wr_data && busy && !fault;
    ss_auto = ctl_q.sso && dir_q[SS_BIT];
  end

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      aux_q  <= '0;
      pre_q  <= '0;
      exp_q  <= '0;
      port_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctl_q.ie  <= bus_wdata[C_IE];
        ctl_q.en  <= bus_wdata[C_EN];
        ctl_q.mst <= bus_wdata[C_MST];
        ctl_q.pol <= bus_wdata[C_POL];
        ctl_q.pha <= bus_wdata[C_PHA];
        ctl_q.sso <= bus_wdata[C_SSO];
        ctl_q.lsb <= bus_wdata[C_LSB];
      end
      if (fault) begin
        ctl_q.en  <= 1'b0;
        ctl_q.mst <= 1'b0;
      end
      if (wr_aux) aux_q <= bus_wdata;
      if (wr_div) begin
        pre_q <= bus_wdata[PRE_LSB +: PRE_W];
        exp_q <= bus_wdata[EXP_LSB +: EXP_W];
      end
      if (wr_port) port_q <= bus_wdata[PORT_W-1:0];
      if (wr_dir)  dir_q  <= bus_wdata[PORT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_hold <= '0;
    else if (done) rx_hold <= rx_next;
  end

  spi_host_baud #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .pre   (pre_q),
    .expo  (exp_q),
    .tick  (tick)
  );

  spi_host_shift #(.DATA_W(REG_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .tx_data   (bus_wdata),
    .cpha      (ctl_q.pha),
    .lsb_first (ctl_q.lsb),
    .tick      (tick),
    .miso      (miso),
    .busy      (busy),
    .sck_tog   (sck_tog),
    .mosi      (mosi_q),
    .done      (done),
    .rx_next   (rx_next)
  );

  spi_host_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_done (done),
    .set_col  (set_col),
    .set_flt  (fault),
    .rd_stat  (rd_stat),
    .rd_data  (rd_data),
    .done_f   (done_f),
    .col_f    (col_f),
    .flt_f    (flt_f)
  );

  // pins
  always_comb begin
    sck       = ctl_q.en ? (ctl_q.pol ^ sck_tog) : ctl_q.pol;
    mosi      = ctl_q.en && mosi_q;
    irq_done  = ctl_q.ie && done_f;
    irq_fault = ctl_q.ie && flt_f;
    port_oe   = dir_q;
  end

  for (genvar gi = 0; gi < PORT_W; gi++) begin : g_port
    if (gi == SS_BIT) begin : g_ss
      assign port_out[gi] = ss_auto ? ~busy : port_q[gi];
    end else begin : g_plain
      assign port_out[gi] = port_q[gi];
    end
  end

  // read mux
  always_comb begin
    stat_v         = '0;
    stat_v[S_DONE] = done_f;
    stat_v[S_COL]  = col_f;
    stat_v[S_FLT]  = flt_f;
    ctl_v          = '0;
    ctl_v[C_IE]    = ctl_q.ie;
    ctl_v[C_EN]    = ctl_q.en;
    ctl_v[C_MST]   = ctl_q.mst;
    ctl_v[C_POL]   = ctl_q.pol;
    ctl_v[C_PHA]   = ctl_q.pha;
    ctl_v[C_SSO]   = ctl_q.sso;
    ctl_v[C_LSB]   = ctl_q.lsb;
    bus_rdata      = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata = ctl_v;
        OFS_AUX:  bus_rdata = aux_q;
        OFS_DIV:  begin
          bus_rdata[PRE_LSB +: PRE_W] = pre_q;
          bus_rdata[EXP_LSB +: EXP_W] = exp_q;
        end
        OFS_STAT: bus_rdata = stat_v;
        OFS_DATA: bus_rdata = rx_hold;
        OFS_PORT: bus_rdata = REG_W'(port_q);
        OFS_DIR:  bus_rdata = REG_W'(dir_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // clock rests at polarity whenever idle
  p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == ctl_q.pol));
  // completion leaves the done flag set
  p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done_f);
  // collision write raises its flag
  p_col_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy && !fault) |=> col_f);
  // fault drops master mode and stops the shifter
  p_fault_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!ctl_q.en && !ctl_q.mst && !busy && flt_f));
endmodule

// File: tb/spi_host_ctrl_tb_top.sv
module spi_host_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          sck, mosi, miso;
  logic [PW-1:0] port_in = '1;
  logic [PW-1:0] port_out, port_oe;
  logic          irq_done, irq_fault;
  logic          inv = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  int tog_cnt = 0;
  logic sck_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = mosi ^ inv;

  spi_host_ctrl #(.PORT_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe),
    .irq_done(irq_done), .irq_fault(irq_fault)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]    m_ctl;
  logic [PW-1:0] m_port, m_dir;
  int            m_half, m_cnt, m_edge;
  bit            m_busy, m_tog, m_mosi;
  logic [7:0]    m_rx, m_tx;
  bit            m_spif, m_wcol, m_modf;
  bit [2:0]      m_arm;
  logic [7:0]    m_div;

  function automatic bit bit_at(input logic [7:0] d, input int i, input bit lsb);
    return lsb ? d[i] : d[7-i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_port = '0; m_dir = '0; m_div = '0;
      m_cnt = 0; m_edge = 0; m_busy = 0; m_tog = 0; m_mosi = 0;
      m_rx = '0; m_tx = '0; m_spif = 0; m_wcol = 0; m_modf = 0; m_arm = '0;
    end else begin
      bit en, mst, pha, lsb, flt, wr_d, rd_s, rd_d, s_done, s_col, lead;
      en   = m_ctl[6]; mst = m_ctl[4]; pha = m_ctl[2]; lsb = m_ctl[0];
      m_half = (int'(m_div[6:4]) + 1) << m_div[2:0];
      flt  = en && mst && !m_dir[3] && !port_in[3];
      wr_d = bus_wr && bus_addr == 5'h09;
      rd_s = bus_rd && bus_addr == 5'h05;
      rd_d = bus_rd && bus_addr == 5'h09;
      s_done = 0;
      s_col  = wr_d && m_busy && !flt;
      if (flt || (m_busy && !(en && mst))) begin
        m_busy = 0; m_cnt = 0; m_edge = 0; m_tog = 0;
      end else if (wr_d && !m_busy && en && mst) begin
        m_busy = 1; m_cnt = 0; m_edge = 0; m_tog = 0; m_tx = bus_wdata;
        if (!pha) m_mosi = bit_at(bus_wdata, 0, lsb);
      end else if (m_busy) begin
        if (m_cnt == m_half - 1) begin
          m_cnt = 0;
          lead  = (m_edge % 2) == 0;
          m_tog = !m_tog;
          if (lead != pha) m_rx = lsb ? {miso, m_rx[7:1]} : {m_rx[6:0], miso};
          if (lead && pha) m_mosi = bit_at(m_tx, m_edge / 2, lsb);
          if (!lead && !pha && m_edge != 15) m_mosi = bit_at(m_tx, m_edge / 2 + 1, lsb);
          if (m_edge == 15) begin
            m_busy = 0; s_done = 1; m_edge = 0;
          end else m_edge++;
        end else m_cnt++;
      end
      if (rd_s) m_arm = {m_spif, m_wcol, m_modf};
      else if (rd_d) begin
        if (m_arm[2]) m_spif = 0;
        if (m_arm[1]) m_wcol = 0;
        if (m_arm[0]) m_modf = 0;
        m_arm = '0;
      end
      if (s_done) m_spif = 1;
      if (s_col)  m_wcol = 1;
      if (flt)    m_modf = 1;
      if (bus_wr && bus_addr == 5'h00) m_ctl = bus_wdata;
      if (bus_wr && bus_addr == 5'h04) m_div = bus_wdata;
      if (bus_wr && bus_addr == 5'h0D) m_port = bus_wdata[PW-1:0];
      if (bus_wr && bus_addr == 5'h10) m_dir = bus_wdata[PW-1:0];
      if (flt) begin m_ctl[6] = 0; m_ctl[4] = 0; end
    end
  end

  // per-cycle comparison of all pins against the model (R3, R9, R10, R11)
  always @(negedge clk) begin
    logic [3+2*PW:0] act, exp;
    logic ss_e;
    logic [PW-1:0] po_e;
    if (cmp_en) begin
      po_e = m_port;
      ss_e = (m_ctl[1] && m_dir[3]) ? !m_busy : m_port[3];
      po_e[3] = ss_e;
      act = {sck, mosi, irq_done, irq_fault, port_out, port_oe};
      exp = {(m_ctl[6] ? (m_ctl[3] ^ m_tog) : m_ctl[3]),
             (m_ctl[6] && m_mosi), (m_ctl[7] && m_spif), (m_ctl[7] && m_modf),
             po_e, m_dir};
      check("R3 R9 R10 R11 pin model", int'(act), int'(exp));
    end
    if (sck !== sck_prev) tog_cnt++;
    sck_prev = sck;
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!irq_done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(req, int'(irq_done), 1);
  endtask

  task automatic xfer(input logic [7:0] ctl, input logic [7:0] dv,
                      input logic [7:0] tx, input logic iv, input logic [7:0] exp_rx);
    logic [7:0] v;
    inv = iv;
    wr(5'h04, dv);
    wr(5'h00, ctl);
    tog_cnt = 0;
    wr(5'h09, tx);
    wait_done("R5 completion irq");
    check("R2 sixteen clock edges", tog_cnt, 16);
    rd(5'h09, v);  check("R4 R5 received byte", int'(v), int'(exp_rx));
    rd(5'h05, v);  check("R6 flag kept after lone data read", int'(v), 8'h80);
    rd(5'h09, v);  check("R5 data reread", int'(v), int'(exp_rx));
    rd(5'h05, v);  check("R6 flag cleared by sequence", int'(v), 8'h00);
    check("R9 irq_done low after clear", int'(irq_done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R1 reset state and readback
    rd(5'h05, v); check("R1 status reset", int'(v), 0);
    rd(5'h00, v); check("R1 control reset", int'(v), 0);
    check("R1 sck idle after reset", int'(sck), 0);
    wr(5'h01, 8'h5A); rd(5'h01, v); check("R1 aux readback", int'(v), 8'h5A);
    wr(5'h04, 8'hFF); rd(5'h04, v); check("R1 divider readback", int'(v), 8'h77);
    wr(5'h10, 8'h0E); rd(5'h10, v); check("R1 direction readback", int'(v), 8'h0E);
    wr(5'h0D, 8'h08); rd(5'h0D, v); check("R1 port readback", int'(v), 8'h08);

    // R10 disabled: nothing starts, pins rest
    wr(5'h00, 8'h18);
    wr(5'h09, 8'hA5);
    repeat (40) @(negedge clk);
    rd(5'h05, v); check("R10 no exchange when disabled", int'(v), 0);
    check("R10 sck at polarity", int'(sck), 1);
    check("R10 mosi low", int'(mosi), 0);

    // main exchanges in all modes
    wr(5'h0D, 8'h00);
    xfer(8'hD0, 8'h00, 8'h96, 1'b0, 8'h96);   // mode 0, msb first, fastest
    xfer(8'hDD, 8'h21, 8'h3C, 1'b1, 8'hC3);   // mode 3, lsb first, inverted
    xfer(8'hD4, 8'h10, 8'hE1, 1'b0, 8'hE1);   // mode 1
    xfer(8'hD8, 8'h02, 8'h4B, 1'b1, 8'hB4);   // mode 2

    // R4 first bit on MOSI follows the order bit
    inv = 1'b0;
    wr(5'h04, 8'h03);
    wr(5'h00, 8'hD1);
    wr(5'h09, 8'h01);
    check("R4 lsb first drives bit 0 first", int'(mosi), 1);
    wait_done("R4 completion");
    rd(5'h05, v); rd(5'h09, v);
    check("R4 lsb loopback byte", int'(v), 8'h01);
    wr(5'h00, 8'hD0);
    wr(5'h09, 8'h01);
    check("R4 msb first drives bit 7 first", int'(mosi), 0);
    wait_done("R4 completion msb");
    rd(5'h05, v); rd(5'h09, v);

    // R7 collision write ignored
    wr(5'h04, 8'h12);
    wr(5'h09, 8'h5A);
    repeat (20) @(negedge clk);
    wr(5'h09, 8'hFF);
    wait_done("R7 completion");
    rd(5'h05, v); check("R7 collision and done flags", int'(v), 8'hC0);
    rd(5'h09, v); check("R7 first byte kept", int'(v), 8'h5A);
    rd(5'h05, v); check("R7 flags cleared", int'(v), 0);

    // R11 automatic slave select
    wr(5'h0D, 8'h08);
    wr(5'h00, 8'hD2);
    wr(5'h04, 8'h03);
    wr(5'h09, 8'h81);
    repeat (3) @(negedge clk);
    check("R11 select low during exchange", int'(port_out[3]), 0);
    wait_done("R11 completion");
    check("R11 select high after exchange", int'(port_out[3]), 1);
    check("R11 output enables", int'(port_oe), 8'h0E);
    rd(5'h05, v); rd(5'h09, v);

    // R8 mode fault aborts and drops master
    wr(5'h10, 8'h06);
    wr(5'h00, 8'hD0);
    wr(5'h04, 8'h77);
    wr(5'h09, 8'h55);
    repeat (10) @(negedge clk);
    port_in[3] = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 fault interrupt", int'(irq_fault), 1);
    rd(5'h05, v); check("R8 fault flag", int'(v), 8'h10);
    rd(5'h00, v); check("R8 master and enable cleared", int'(v), 8'h80);
    port_in[3] = 1'b1;
    rd(5'h09, v);
    rd(5'h05, v); check("R8 fault cleared by sequence", int'(v), 0);
    check("R9 fault interrupt low", int'(irq_fault), 0);
    repeat (60) @(negedge clk);
    rd(5'h05, v); check("R8 aborted exchange never completes", int'(v), 0);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule